// File: doc/BRIEF.md
# Clear-on-Read Interrupt Status Controller

This block collects single-cycle event pulses from up to sixteen sources of a peripheral and latches them into two 8-bit status registers. Two read/write enable registers select which latched events may pull an active-low interrupt request low. Disabled events still latch and remain visible to software.

Software uses a simple synchronous register bus with an 8-bit address, read and write strobes, and byte-wide data. Reading a status register returns its value from before the read. The read then clears only the bits whose enable is set, and the request line releases until a new enabled event is latched. A read-only register holds a 5-bit version code.

Top module: `intStatusCtrl`

## Requirements
- R1: After reset both status registers read 00h, the enable register at 05h reads 00h, the enable register at 06h reads 01h, and irqN is high.
- R2: A pulse on evt1[n] sets bit n of status register 03h, and a pulse on evt2[n] sets bit n of status register 04h. Bit n of enable register 05h or 06h gates status bit n of 03h or 04h respectively.
- R3: Bits 6, 5 and 2 of register 03h always read zero, and the same bits of register 05h cannot be set. Writing FFh to 05h reads back 9Bh.
- R4: irqN is registered. It is low in the cycle after any status bit is set together with its enable, and high in the cycle after no such pair exists.
- R5: A read of 03h or 04h returns the value from before the read, then clears every bit of that register whose enable is set. irqN goes high one clock later when nothing enabled remains.
- R6: A status bit whose enable is clear keeps its value through a status read, and it never pulls irqN low.
- R7: An event pulse that arrives in the same cycle as a clearing read of its register leaves the bit set after the read.
- R8: Setting the enable of a status bit that is already latched drives irqN low one clock after the enable write.
- R9: Address 01h returns the 5-bit version code parameter in bits 4:0, and bits 7:5 read as zero.
- R10: Writes to addresses 01h, 03h, 04h or any unmapped address change no state. Reads of unmapped addresses return 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evt1 | input | 8 | Event pulses for status register 03h |
| evt2 | input | 8 | Event pulses for status register 04h |
| busAddr | input | 8 | Register address |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe, clears enabled status bits |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for the addressed register, same cycle |
| irqN | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that busRd and busWr are never high in the same cycle. They also assume that any event on a bit being cleared by a read is itself the reason that bit survives. For this reason the clear check excludes bits that have a pulse in the read cycle. The bench drives every input on the falling clock edge, holds each strobe for exactly one cycle, and never asserts read and write together. This keeps the stimulus within those assumptions. The event bits that are sent to reserved positions still drive the inputs, so the masking itself is exercised.

// File: rtl/intStatusPkg.sv
package intStatusPkg;
  localparam int NUM_REGS = 2;
  localparam int DATA_W = 8;
  localparam int VER_W = 5;

  localparam logic [7:0] ADDR_VER = 8'h01;
  localparam logic [7:0] ADDR_STAT_BASE = 8'h03;
  localparam logic [7:0] ADDR_EN_BASE = 8'h05;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_VER,
    SEL_STAT,
    SEL_EN
  } rdSel_e;

  typedef struct packed {
    logic [NUM_REGS-1:0] rdStat;
    logic [NUM_REGS-1:0] wrEn;
    rdSel_e rdSel;
    logic [$clog2(NUM_REGS)-1:0] rdIdx;
  } strobe_t;

  function automatic logic [DATA_W-1:0] implMask(input int idx);
    return (idx == 0) ? 8'h9B : 8'hFF;
  endfunction

  function automatic logic [DATA_W-1:0] enResetVal(input int idx);
    return (idx == 0) ? 8'h00 : 8'h01;
  endfunction
endpackage

// File: rtl/intCtrl.sv
module intCtrl
  import intStatusPkg::*;
(
  input  logic [7:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  output strobe_t    strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    if (busAddr == ADDR_VER) strb.rdSel = SEL_VER;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (busAddr == ADDR_STAT_BASE + 8'(i)) begin
        strb.rdSel = SEL_STAT;
        strb.rdIdx = i[$clog2(NUM_REGS)-1:0];
        strb.rdStat[i] = busRd;
      end
      if (busAddr == ADDR_EN_BASE + 8'(i)) begin
        strb.rdSel = SEL_EN;
        strb.rdIdx = i[$clog2(NUM_REGS)-1:0];
        strb.wrEn[i] = busWr;
      end
    end
  end
endmodule

// File: rtl/intDatapath.sv
module intDatapath
  import intStatusPkg::*;
#(
  parameter logic [VER_W-1:0] VER_CODE = 5'h06
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] evtIn,
  input  strobe_t                         strb,
  input  logic [DATA_W-1:0]               wdata,
  output logic [DATA_W-1:0]               rdata,
  output logic [NUM_REGS-1:0][DATA_W-1:0] statQ,
  output logic [NUM_REGS-1:0][DATA_W-1:0] enQ,
  output logic                            irqN
);
  logic [NUM_REGS-1:0] pendReg;
  logic irqQ;

  for (genvar g = 0; g < NUM_REGS; g++) begin : gReg
    localparam logic [DATA_W-1:0] IMPL = implMask(g);
    localparam logic [DATA_W-1:0] EN_RST = enResetVal(g);
    logic [DATA_W-1:0] clrMask;

    assign clrMask = strb.rdStat[g] ? enQ[g] : '0;
    assign pendReg[g] = |(statQ[g] & enQ[g]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statQ[g] <= '0;
        enQ[g] <= EN_RST;
      end else begin
        statQ[g] <= ((statQ[g] & ~clrMask) | evtIn[g]) & IMPL;
        if (strb.wrEn[g]) enQ[g] <= wdata & IMPL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) irqQ <= 1'b0;
    else irqQ <= |pendReg;
  end
  assign irqN = ~irqQ;

  always_comb begin
    unique case (strb.rdSel)
      SEL_VER:  rdata = {{(DATA_W-VER_W){1'b0}}, VER_CODE};
      SEL_STAT: rdata = statQ[strb.rdIdx];
      SEL_EN:   rdata = enQ[strb.rdIdx];
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/intStatusCtrl.sv
module intStatusCtrl
  import intStatusPkg::*;
#(
  parameter logic [VER_W-1:0] VER_CODE = 5'h06
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] evt1,
  input  logic [7:0] evt2,
  input  logic [7:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       irqN
);
  strobe_t strb;
  logic [NUM_REGS-1:0][DATA_W-1:0] evtIn;
  logic [NUM_REGS-1:0][DATA_W-1:0] statQ;
  logic [NUM_REGS-1:0][DATA_W-1:0] enQ;

  assign evtIn[0] = evt1;
  assign evtIn[1] = evt2;

  intCtrl i_ctrl (
    .busAddr(busAddr),
    .busWr(busWr),
    .busRd(busRd),
    .strb(strb)
  );

  intDatapath #(.VER_CODE(VER_CODE)) i_dp (
    .clk(clk),
    .rstN(rstN),
    .evtIn(evtIn),
    .strb(strb),
    .wdata(busWdata),
    .rdata(busRdata),
    .statQ(statQ),
    .enQ(enQ),
    .irqN(irqN)
  );
endmodule

// File: rtl/intStatusChecker.sv
module intStatusChecker (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] evt1,
  input logic [7:0] busAddr,
  input logic       busRd,
  input logic [7:0] busRdata,
  input logic       irqN,
  input logic [7:0] stat1,
  input logic [7:0] stat2,
  input logic [7:0] en1,
  input logic [7:0] en2
);
  logic mapped;
  assign mapped = (busAddr == 8'h01) || (busAddr == 8'h03) || (busAddr == 8'h04) ||
                  (busAddr == 8'h05) || (busAddr == 8'h06);

  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> irqN == !$past(|((stat1 & en1) | (stat2 & en2)))); // R4

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ((stat1 & 8'h64) == 8'h00) && ((en1 & 8'h64) == 8'h00)); // R3

  AST_CLEAR_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 8'h03) |=> (stat1 & $past(en1) & ~$past(evt1)) == 8'h00); // R5

  AST_EVT_KEPT: assert property (@(posedge clk) disable iff (!rstN)
    (|(evt1 & 8'h9B)) |=> (stat1 & $past(evt1 & 8'h9B)) == $past(evt1 & 8'h9B)); // R7

  AST_DISABLED_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == 8'h04) |=> (stat2 & $past(stat2 & ~en2)) == $past(stat2 & ~en2)); // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> busRdata == 8'h00); // R10

  AST_VERSION_UPPER: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 8'h01) |-> busRdata[7:5] == 3'b000); // R9
endmodule

bind intStatusCtrl intStatusChecker i_chk (
  .clk(clk),
  .rstN(rstN),
  .evt1(evt1),
  .busAddr(busAddr),
  .busRd(busRd),
  .busRdata(busRdata),
  .irqN(irqN),
  .stat1(statQ[0]),
  .stat2(statQ[1]),
  .en1(enQ[0]),
  .en2(enQ[1])
);

// File: tb/test_intStatusCtrl.sv
`timescale 1ns/1ps
module test_intStatusCtrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] evt1 = '0, evt2 = '0, busAddr = '0, busWdata = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busRdata;
  logic irqN;
  int nChecks = 0;
  int nFails = 0;
  bit doneFlag = 0;

  localparam logic [4:0] VER = 5'h0B;

  always #5 clk = ~clk;

  intStatusCtrl #(.VER_CODE(VER)) i_intStatusCtrl (
    .clk(clk), .rstN(rstN), .evt1(evt1), .evt2(evt2), .busAddr(busAddr),
    .busWr(busWr), .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata), .irqN(irqN)
  );

  typedef struct packed {
    logic [7:0] e1, e2, en1, en2;
    logic irqLow;
    logic [7:0] s1, s2;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{8'h01, 8'h00, 8'h01, 8'h00, 1'b1, 8'h01, 8'h00},
    '{8'h10, 8'h80, 8'h00, 8'h00, 1'b0, 8'h10, 8'h80},
    '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b1, 8'h9B, 8'hFF},
    '{8'h08, 8'h04, 8'h00, 8'h04, 1'b1, 8'h08, 8'h04}
  };

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busAddr = 8'h00;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0; busAddr = 8'h00;
  endtask

  task automatic pulse(input logic [7:0] a, input logic [7:0] b);
    @(negedge clk);
    evt1 = a; evt2 = b;
    @(negedge clk);
    evt1 = '0; evt2 = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!doneFlag) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle();
    // R1 reset state
    check(irqN === 1'b1, "R1 irqN", {7'b0, irqN}, 8'h01);
    readReg(8'h03, d); check(d === 8'h00, "R1 stat1", d, 8'h00);
    readReg(8'h04, d); check(d === 8'h00, "R1 stat2", d, 8'h00);
    readReg(8'h05, d); check(d === 8'h00, "R1 en1", d, 8'h00);
    readReg(8'h06, d); check(d === 8'h01, "R1 en2", d, 8'h01);
    // R9 version
    readReg(8'h01, d); check(d === {3'b000, VER}, "R9 version", d, {3'b000, VER});

    // Vector table: R2 R4 R5 R6
    for (int i = 0; i < 4; i++) begin
      logic [7:0] m1;
      m1 = VECS[i].en1 & 8'h9B;
      writeReg(8'h05, VECS[i].en1);
      writeReg(8'h06, VECS[i].en2);
      pulse(VECS[i].e1, VECS[i].e2);
      idle();
      check(irqN === !VECS[i].irqLow, "R4 irq level", {7'b0, irqN}, {7'b0, !VECS[i].irqLow});
      readReg(8'h03, d); check(d === VECS[i].s1, "R2 stat1 latch", d, VECS[i].s1);
      readReg(8'h04, d); check(d === VECS[i].s2, "R2 stat2 latch", d, VECS[i].s2);
      idle();
      check(irqN === 1'b1, "R5 irq release", {7'b0, irqN}, 8'h01);
      readReg(8'h03, d); check(d === (VECS[i].s1 & ~m1), "R6 stat1 residue", d, VECS[i].s1 & ~m1);
      readReg(8'h04, d); check(d === (VECS[i].s2 & ~VECS[i].en2), "R6 stat2 residue", d, VECS[i].s2 & ~VECS[i].en2);
      writeReg(8'h05, 8'hFF);
      writeReg(8'h06, 8'hFF);
      readReg(8'h03, d);
      readReg(8'h04, d);
      idle();
    end

    // R3 reserved enables
    writeReg(8'h05, 8'hFF);
    readReg(8'h05, d); check(d === 8'h9B, "R3 en1 mask", d, 8'h9B);

    // R7 event concurrent with clearing read
    writeReg(8'h05, 8'h01);
    pulse(8'h01, 8'h00);
    @(negedge clk);
    busAddr = 8'h03; busRd = 1'b1; evt1 = 8'h01;
    #1 d = busRdata;
    check(d === 8'h01, "R5 pre-clear data", d, 8'h01);
    @(negedge clk);
    busRd = 1'b0; evt1 = 8'h00; busAddr = 8'h00;
    readReg(8'h03, d); check(d === 8'h01, "R7 event kept", d, 8'h01);
    idle();

    // R8 late enable
    writeReg(8'h06, 8'h00);
    pulse(8'h00, 8'h08);
    idle();
    check(irqN === 1'b1, "R6 disabled no irq", {7'b0, irqN}, 8'h01);
    writeReg(8'h06, 8'h08);
    check(irqN === 1'b1, "R8 before edge", {7'b0, irqN}, 8'h01);
    idle();
    check(irqN === 1'b0, "R8 late enable irq", {7'b0, irqN}, 8'h00);
    readReg(8'h04, d);
    idle();

    // R10 ignored writes and unmapped reads
    pulse(8'h00, 8'h02);
    writeReg(8'h04, 8'h00);
    writeReg(8'h01, 8'hFF);
    writeReg(8'h07, 8'hFF);
    writeReg(8'h15, 8'hFF);
    readReg(8'h04, d); check(d === 8'h02, "R10 ro write ignored", d, 8'h02);
    readReg(8'h01, d); check(d === {3'b000, VER}, "R10 version unchanged", d, {3'b000, VER});
    readReg(8'h06, d); check(d === 8'h08, "R10 en2 untouched", d, 8'h08);
    readReg(8'h07, d); check(d === 8'h00, "R10 unmapped read", d, 8'h00);
    readReg(8'h20, d); check(d === 8'h00, "R10 unmapped read hi", d, 8'h00);

    doneFlag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule